// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between a 32-bit integer pipeline and a byte-addressed data memory port. On each request it forms the effective address from a base register value and a signed 16-bit displacement, the only addressing mode. It checks that the access is naturally aligned for its size. For a store it drives the memory request with byte enables and write data. A load request is issued to memory, and the returned word is later reduced to the addressed byte or halfword and widened to 32 bits.

Alignment is strict. A byte access is always legal. A halfword must sit on an even address, and a word must sit on a multiple of four. A request that breaks this rule is not split and does not reach memory: the unit raises an address-error pulse and latches the offending address instead.

A parameter selects little or big byte ordering, which sets the mapping from byte address to byte lane. Request outputs are registered one cycle after the request. The load result is registered one cycle after the memory response. One load is outstanding at a time.

Top module: `lsu_align`

## Requirements
- R1: One cycle after `req_valid`, `mem_addr` equals `req_base` plus `req_imm` sign-extended to 32 bits (modulo 2^32). It holds that value until the next request.
- R2: A byte access (`req_size`=0) is never misaligned. It enables one lane: lane equal to the address offset (`addr[1:0]`) when `BIG_ENDIAN`=0, and lane 3 minus the offset when `BIG_ENDIAN`=1 (lane n is `mem_be[n]`, data bits 8n+7..8n).
- R3: A halfword access (`req_size`=1) at an odd address is misaligned.
- R4: A word access (`req_size`=2 or 3) whose address is not a multiple of four is misaligned.
- R5: A legal request pulses `mem_req` for one cycle, with `mem_we` equal to `req_store`. A misaligned request instead pulses `addr_err` for one cycle with `mem_req`, `mem_we` and `mem_be` all zero. `fault_addr` takes the effective address of each misaligned request and holds it until the next one.
- R6: A halfword enables two lanes: 0,1 for offset 0 and 2,3 for offset 2 when little-endian; 2,3 for offset 0 and 0,1 for offset 2 when big-endian. A word enables all four lanes. `mem_be` is zero in any cycle without a legal request.
- R7: `mem_wdata` carries the low byte of `req_wdata` copied to all four lanes for a byte access, the low halfword copied to both halves for a halfword, and `req_wdata` unchanged for a word.
- R8: A byte load returns the addressed lane of `mem_rdata`. It is zero-extended when `req_unsigned`=1 and sign-extended otherwise.
- R9: A halfword load returns the addressed halfword. In little-endian the byte at the lower address is the low byte; in big-endian it is the high byte. It is zero- or sign-extended as in R8.
- R10: A word load returns `mem_rdata` unchanged whatever `req_unsigned` is.
- R11: `ld_valid` is `mem_rvalid` delayed by one cycle. `ld_data` updates only in that cycle and holds otherwise, using the size, signedness and offset of the most recent legal load.
- R12: While `rst_n` is low every output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend a sub-word load |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rvalid | input | 1 | Load data returned this cycle |
| mem_rdata | input | 32 | Returned memory word |
| addr_err | output | 1 | Misalignment pulse |
| fault_addr | output | 32 | Address of the last misaligned access |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench builds two copies of the unit, one with `BIG_ENDIAN`=0 and one with `BIG_ENDIAN`=1. Both copies get the same stimulus, so every offset, size and signedness reaches both lane mappings. The patterns are chosen so the two orderings give different enables and results. A negative displacement checks that the effective-address sum carries across bit 16. Load responses that arrive in the same cycle as a new request check that extension uses the earlier load's context.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_unsigned,
  input  logic [31:0] req_base,
  input  logic [15:0] req_imm,
  input  logic [31:0] req_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        addr_err,
  output logic [31:0] fault_addr,
  output logic        ld_valid,
  output logic [31:0] ld_data
);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  logic [31:0] ea;
  logic [1:0]  ofs;
  logic        misal, go;
  logic [3:0]  be_n;
  logic [31:0] wd_n;
  logic [1:0]  sh_n;
  logic [1:0]  ld_sz;
  logic        ld_uns;
  logic [1:0]  ld_sh;
  logic [31:0] lane_dat, ext_dat;

  assign ea  = req_base + {{16{req_imm[15]}}, req_imm};
  assign ofs = ea[1:0];
  assign go  = req_valid && !misal;

  always_comb begin
    case (req_size)
      SZ_BYTE: begin
        misal = 1'b0;
        be_n  = BIG_ENDIAN ? (4'b1000 >> ofs) : (4'b0001 << ofs);
        wd_n  = {4{req_wdata[7:0]}};
        sh_n  = BIG_ENDIAN ? (2'd3 - ofs) : ofs;
      end
      SZ_HALF: begin
        misal = ea[0];
        be_n  = BIG_ENDIAN ? (4'b1100 >> ofs) : (4'b0011 << ofs);
        wd_n  = {2{req_wdata[15:0]}};
        sh_n  = BIG_ENDIAN ? (2'd2 - ofs) : ofs;
      end
      default: begin
        misal = |ofs;
        be_n  = 4'b1111;
        wd_n  = req_wdata;
        sh_n  = 2'd0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      addr_err   <= 1'b0;
      fault_addr <= '0;
      ld_sz      <= '0;
      ld_uns     <= 1'b0;
      ld_sh      <= '0;
    end else begin
      mem_req  <= go;
      mem_we   <= go && req_store;
      mem_be   <= go ? be_n : 4'b0000;
      addr_err <= req_valid && misal;
      if (req_valid) begin
        mem_addr  <= ea;
        mem_wdata <= wd_n;
      end
      if (req_valid && misal) fault_addr <= ea;
      if (go && !req_store) begin
        ld_sz  <= req_size;
        ld_uns <= req_unsigned;
        ld_sh  <= sh_n;
      end
    end
  end

  assign lane_dat = mem_rdata >> {ld_sh, 3'b000};

  always_comb begin
    case (ld_sz)
      SZ_BYTE: ext_dat = {{24{!ld_uns && lane_dat[7]}}, lane_dat[7:0]};
      SZ_HALF: ext_dat = {{16{!ld_uns && lane_dat[15]}}, lane_dat[15:0]};
      default: ext_dat = lane_dat;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= mem_rvalid;
      if (mem_rvalid) ld_data <= ext_dat;
    end
  end

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!mem_req && !mem_we && mem_be == 4'b0000));
  // R5
  req_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_req && !addr_err));
  // R4
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be == 4'b1111) |-> mem_addr[1:0] == 2'b00);
  // R3
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $countones(mem_be) == 2) |-> !mem_addr[0]);
  // R6
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                 mem_be == 4'b1100 || mem_be == 4'b1111));
  // R7
  byte_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $countones(mem_be) == 1) |->
      (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[15:8] == mem_wdata[7:0]));
  // R11
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rvalid |=> $stable(ld_data));
  // R8
  byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_sz == SZ_BYTE && ld_uns) |-> ld_data[31:8] == 24'h0);
endmodule

// File: tb/lsu_align_test.sv
module lsu_align_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_unsigned = 0, mem_rvalid = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_base = 0, req_wdata = 0, mem_rdata = 0;
  logic [15:0] req_imm = 0;

  logic        o_req[2], o_we[2], o_err[2], o_lv[2];
  logic [31:0] o_addr[2], o_wd[2], o_fa[2], o_ld[2];
  logic [3:0]  o_be[2];

  logic        x_req[2], x_we[2], x_err[2], x_lv[2];
  logic [31:0] x_addr[2], x_wd[2], x_fa[2], x_ld[2];
  logic [3:0]  x_be[2];
  int          c_sz[2], c_ofs[2];
  logic        c_uns[2];
  int          tag_sz = 2, tag_ld = 2;
  logic        in_reset = 1'b1;

  int checks = 0, errors = 0;

  lsu_align #(.BIG_ENDIAN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_imm(req_imm), .req_wdata(req_wdata), .mem_req(o_req[0]), .mem_we(o_we[0]),
    .mem_addr(o_addr[0]), .mem_be(o_be[0]), .mem_wdata(o_wd[0]),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .addr_err(o_err[0]),
    .fault_addr(o_fa[0]), .ld_valid(o_lv[0]), .ld_data(o_ld[0]));

  lsu_align #(.BIG_ENDIAN(1'b1)) uut_be (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_imm(req_imm), .req_wdata(req_wdata), .mem_req(o_req[1]), .mem_we(o_we[1]),
    .mem_addr(o_addr[1]), .mem_be(o_be[1]), .mem_wdata(o_wd[1]),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .addr_err(o_err[1]),
    .fault_addr(o_fa[1]), .ld_valid(o_lv[1]), .ld_data(o_ld[1]));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: updated on each rising edge from the inputs held stable since the last falling edge
  always @(posedge clk) begin
    for (int e = 0; e < 2; e++) begin
      if (!rst_n) begin
        x_req[e] = 0; x_we[e] = 0; x_err[e] = 0; x_lv[e] = 0;
        x_addr[e] = 0; x_wd[e] = 0; x_fa[e] = 0; x_ld[e] = 0; x_be[e] = 0;
        c_sz[e] = 0; c_ofs[e] = 0; c_uns[e] = 0;
      end else begin
        x_lv[e] = mem_rvalid;
        if (mem_rvalid) begin
          logic [7:0] byt[4];
          int v;
          for (int k = 0; k < 4; k++)
            byt[k] = e ? mem_rdata[8*(3-k) +: 8] : mem_rdata[8*k +: 8];
          if (c_sz[e] == 0) begin
            v = byt[c_ofs[e]];
            if (!c_uns[e] && v >= 128) v = v - 256;
            x_ld[e] = v;
          end else if (c_sz[e] == 1) begin
            v = e ? byt[c_ofs[e]] * 256 + byt[c_ofs[e]+1] : byt[c_ofs[e]+1] * 256 + byt[c_ofs[e]];
            if (!c_uns[e] && v >= 32768) v = v - 65536;
            x_ld[e] = v;
          end else x_ld[e] = mem_rdata;
          if (e == 0) tag_ld = c_sz[e];
        end
        x_req[e] = 0; x_we[e] = 0; x_err[e] = 0; x_be[e] = 0;
        if (req_valid) begin
          logic [31:0] ea;
          int n, o;
          logic bad;
          ea = req_base + 32'($signed(req_imm));
          o = int'(ea[1:0]);
          n = (req_size == 0) ? 1 : (req_size == 1) ? 2 : 4;
          bad = (o % n) != 0;
          x_addr[e] = ea;
          x_wd[e] = (n == 1) ? {4{req_wdata[7:0]}} : (n == 2) ? {2{req_wdata[15:0]}} : req_wdata;
          if (bad) begin
            x_err[e] = 1; x_fa[e] = ea;
          end else begin
            x_req[e] = 1; x_we[e] = req_store;
            for (int k = o; k < o + n; k++) x_be[e][e ? 3-k : k] = 1'b1;
            if (!req_store) begin c_sz[e] = (n == 4) ? 2 : n - 1; c_ofs[e] = o; c_uns[e] = req_unsigned; end
          end
          if (e == 0) tag_sz = n == 4 ? 2 : n - 1;
        end
      end
    end
    in_reset = !rst_n;
  end

  task automatic check(input string tag, input string what, input int e,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s (big=%0d): actual %h expected %h", in_reset ? "R12" : tag, what, e, act, exp);
    end
  endtask

  always @(negedge clk) begin
    for (int e = 0; e < 2; e++) begin
      check("R1", "mem_addr", e, o_addr[e], x_addr[e]);
      check(tag_sz == 0 ? "R2" : "R6", "mem_be", e, 32'(o_be[e]), 32'(x_be[e]));
      check(tag_sz == 0 ? "R2" : tag_sz == 1 ? "R3" : "R4", "addr_err", e, 32'(o_err[e]), 32'(x_err[e]));
      check("R5", "mem_req", e, 32'(o_req[e]), 32'(x_req[e]));
      check("R5", "mem_we", e, 32'(o_we[e]), 32'(x_we[e]));
      check("R5", "fault_addr", e, o_fa[e], x_fa[e]);
      check("R7", "mem_wdata", e, o_wd[e], x_wd[e]);
      check("R11", "ld_valid", e, 32'(o_lv[e]), 32'(x_lv[e]));
      check(tag_ld == 0 ? "R8" : tag_ld == 1 ? "R9" : "R10", "ld_data", e, o_ld[e], x_ld[e]);
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic issue(input logic st, input logic [1:0] sz, input logic uns,
                       input logic [31:0] base, input logic [15:0] imm, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = sz; req_unsigned = uns;
    req_base = base; req_imm = imm; req_wdata = wd;
    mem_rvalid = 0;
  endtask

  task automatic respond(input logic [31:0] rd);
    @(negedge clk);
    req_valid = 0;
    mem_rvalid = 1; mem_rdata = rd;
  endtask

  task automatic idle;
    @(negedge clk);
    req_valid = 0; mem_rvalid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    // R8 R9 R10: loads over every size, offset and signedness, with a negative displacement
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++)
        for (int u = 0; u < 2; u++) begin
          issue(0, 2'(sz), u[0], 32'h0000_2008 + o, 16'hFFF8, 32'h0);
          respond(32'h80F1_7F02);
          issue(0, 2'(sz), u[0], 32'h1234_FFF0 + o, 16'h0010, 32'h0);
          respond(32'h7E80_01FF);
        end
    // R2 R6 R7 R3 R4 R5: stores at every offset, including misaligned ones
    for (int sz = 0; sz < 3; sz++)
      for (int o = 0; o < 4; o++) begin
        issue(1, 2'(sz), 0, 32'h4000_0000 + o, 16'h7FFF - 16'h3, 32'hA5C3_5A3C);
        idle();
      end
    // R11: response in the same cycle as a following request, then back-to-back requests
    issue(0, 2'd0, 0, 32'h100, 16'h0001, 0);
    @(negedge clk);
    req_valid = 1; req_store = 0; req_size = 2'd1; req_unsigned = 1; req_base = 32'h202; req_imm = 0;
    mem_rvalid = 1; mem_rdata = 32'h1122_83F4;
    respond(32'hFEDC_8A98);
    issue(0, 2'd2, 0, 32'h301, 16'h0, 0);
    issue(1, 2'd1, 0, 32'h303, 16'h0, 32'h0000_BEEF);
    issue(1, 2'd1, 0, 32'h302, 16'h0, 32'h0000_BEEF);
    respond(32'h0BAD_F00D);
    idle();
    idle();
    // R12: reset mid-stream clears all outputs
    issue(1, 2'd2, 0, 32'h500, 16'h0, 32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 0; req_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    idle();
    idle();
    finish_run();
  end
endmodule